// File: doc/BRIEF.md
# SCSI Arbitration and Selection Sequencer

This block carries out host commands that acquire a parallel SCSI bus and address a target on it. A command byte is accepted while the sequencer is idle. An arbitrate command drops every line the controller drives and waits for the bus to go free. It then holds off for the bus-free and settle times and raises BSY together with its own ID bit. After the arbitration delay it decides whether it won. A select command drives the initiator and target ID bits with SEL, and ATN when asked. It then waits a bounded time for the target to answer with BSY.

The remaining commands finish at once. One of them also pulses a soft-reset request to the register block that owns this sequencer. Each command that the sequencer performs ends with a one-cycle done pulse. An arbitration loss or a selection timeout pulses its own exception flag in the same cycle. Every delay is a clock-cycle count set by a parameter and is timed by a single shared down-counter.

Top module: `scsi_arbsel_seq`

## Requirements
- R1: Only bits 3:0 of `cmd_code` pick the operation: 1 arbitrate, 2 select, 3 bus-free, 4 enable-reselect, 5 disable-reselect, 6 reset. Bits 7:6 and 4 have no effect, and bit 5 is read only by select.
- R2: An accepted command 3, 4, 5 or 6 pulses `cmd_done` in the cycle after acceptance with no exception. Command 6 also pulses `soft_rst` in that same cycle.
- R3: Arbitrate first releases `id_out`, `bsy_out`, `sel_out` and `atn_out`. While `bus_bsy_in` or `bus_sel_in` is high it drives no line and does not complete, rechecking every bus-free delay.
- R4: Once the bus is free the sequencer waits the bus-free plus settle delays. If the bus is busy again at that point, it releases its lines, waits the bus-clear delay and goes back to waiting for bus-free.
- R5: At arbitration start it drives `bsy_out` and bit `src_id` of `id_out`. After the arbitration delay it wins when `bus_id_in` has no bit above `src_id` and `bus_sel_in` is low. A win raises `sel_out`, keeps BSY and the ID bit, and pulses `cmd_done` without an exception.
- R6: An arbitration loss releases all lines and pulses `exc_arb_lost` together with `cmd_done`.
- R7: Select drives `id_out` with the bits `src_id` and `dst_id`, sets `sel_out`, clears `bsy_out` and sets `atn_out` equal to bit 5 of the command.
- R8: When `bus_bsy_in` rises during selection, `sel_out` is released and `cmd_done` pulses without an exception, while the ID bits and ATN stay driven.
- R9: If no BSY arrives within `SEL_TMO_CYC` cycles, all lines are released and `exc_sel_tmo` pulses together with `cmd_done`.
- R10: Codes 0 and 7 to 15 leave the sequencer idle and raise no `cmd_done`.
- R11: `busy` is high from the acceptance of an arbitrate or select command until its done cycle. Commands presented while `busy` is high are ignored.
- R12: After reset all bus outputs, `busy` and the pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_code | input | 8 | Command byte |
| src_id | input | IDX_W | Own device number |
| dst_id | input | IDX_W | Target device number |
| bus_id_in | input | NUM_IDS | ID lines driven by other devices |
| bus_bsy_in | input | 1 | BSY from other devices |
| bus_sel_in | input | 1 | SEL from other devices |
| id_out | output | NUM_IDS | ID lines driven by this controller |
| bsy_out | output | 1 | BSY driven by this controller |
| sel_out | output | 1 | SEL driven by this controller |
| atn_out | output | 1 | ATN driven by this controller |
| busy | output | 1 | Arbitrate or select in progress |
| cmd_done | output | 1 | Command completion pulse |
| exc_arb_lost | output | 1 | Arbitration lost pulse |
| exc_sel_tmo | output | 1 | Selection timeout pulse |
| soft_rst | output | 1 | Soft reset request pulse |

## Verification
The bench puts a higher ID on the bus and, separately, a foreign SEL during the arbitration window. A judge that ignored either case would report a win and leave SEL driven. It also makes the bus busy just after the free check, so that it is busy again at arbitration start. A sequencer without the recheck would drive BSY and its ID onto an occupied bus. Selection is run both with and without a target answer, and the timeout latency is measured. A timer started at the wrong time would report too early or hang. Commands sent while busy, and codes with stray upper bits, would show up as extra or misclassified done pulses.

// File: rtl/scsi_arbsel_pkg.sv
package scsi_arbsel_pkg;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_ARB     = 3'd1,
    OP_SEL     = 3'd2,
    OP_BUSFREE = 3'd3,
    OP_ENRESEL = 3'd4,
    OP_DISRES  = 3'd5,
    OP_RESET   = 3'd6
  } op_t;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_FREE_CHK  = 3'd1,
    ST_WAIT      = 3'd2,
    ST_ARB_START = 3'd3,
    ST_ARB_END   = 3'd4,
    ST_SEL_WAIT  = 3'd5
  } state_t;

endpackage

// File: rtl/seq_cmd_decode.sv
module seq_cmd_decode
  import scsi_arbsel_pkg::*;
(
  input  logic [7:0] code,
  output op_t        op,
  output logic       atn_req
);
  logic unused_code_bits;
  assign unused_code_bits = ^{code[7:6], code[4]};
  assign atn_req = code[5];

  always_comb begin
    case (code[3:0])
      4'd1:    op = OP_ARB;
      4'd2:    op = OP_SEL;
      4'd3:    op = OP_BUSFREE;
      4'd4:    op = OP_ENRESEL;
      4'd5:    op = OP_DISRES;
      4'd6:    op = OP_RESET;
      default: op = OP_NONE;
    endcase
  end
endmodule

// File: rtl/seq_delay_timer.sv
module seq_delay_timer #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;
  logic          cnt_en;

  assign cnt_en  = load || (cnt_q != '0);
  assign expired = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      if (load) cnt_q <= load_val;
      else      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/seq_arb_judge.sv
module seq_arb_judge #(
  parameter int NUM_IDS = 8,
  localparam int IDX_W  = $clog2(NUM_IDS)
) (
  input  logic [IDX_W-1:0]   own_idx,
  input  logic [IDX_W-1:0]   tgt_idx,
  input  logic [NUM_IDS-1:0] bus_id,
  input  logic               bus_sel,
  output logic [NUM_IDS-1:0] own_bit,
  output logic [NUM_IDS-1:0] tgt_bit,
  output logic               win
);
  logic [NUM_IDS-1:0] above_own;

  for (genvar i = 0; i < NUM_IDS; i++) begin : g_bit
    assign own_bit[i]   = (own_idx == IDX_W'(i));
    assign tgt_bit[i]   = (tgt_idx == IDX_W'(i));
    assign above_own[i] = (own_idx < IDX_W'(i));
  end

  assign win = ((bus_id & above_own) == '0) && !bus_sel;
endmodule

// File: rtl/scsi_arbsel_seq.sv
module scsi_arbsel_seq
  import scsi_arbsel_pkg::*;
#(
  parameter int NUM_IDS        = 8,
  parameter int BUS_FREE_CYC   = 40,
  parameter int SETTLE_CYC     = 20,
  parameter int CLEAR_CYC      = 40,
  parameter int ARB_CYC        = 120,
  parameter int SEL_TMO_CYC    = 12_500_000,
  localparam int IDX_W         = $clog2(NUM_IDS),
  localparam int FREE_SET_CYC  = BUS_FREE_CYC + SETTLE_CYC,
  localparam int MAX_A         = (FREE_SET_CYC > ARB_CYC) ? FREE_SET_CYC : ARB_CYC,
  localparam int MAX_B         = (CLEAR_CYC > SEL_TMO_CYC) ? CLEAR_CYC : SEL_TMO_CYC,
  localparam int MAX_CYC       = (MAX_A > MAX_B) ? MAX_A : MAX_B,
  localparam int CW            = $clog2(MAX_CYC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [7:0]         cmd_code,
  input  logic [IDX_W-1:0]   src_id,
  input  logic [IDX_W-1:0]   dst_id,
  input  logic [NUM_IDS-1:0] bus_id_in,
  input  logic               bus_bsy_in,
  input  logic               bus_sel_in,
  output logic [NUM_IDS-1:0] id_out,
  output logic               bsy_out,
  output logic               sel_out,
  output logic               atn_out,
  output logic               busy,
  output logic               cmd_done,
  output logic               exc_arb_lost,
  output logic               exc_sel_tmo,
  output logic               soft_rst
);
  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  op_t                op;
  logic               atn_req;
  logic [NUM_IDS-1:0] own_bit, tgt_bit;
  logic               arb_win;
  logic               tmr_load, tmr_expired;
  logic [CW-1:0]      tmr_val;
  logic               bus_free;

  seq_cmd_decode u_dec (
    .code    (cmd_code),
    .op      (op),
    .atn_req (atn_req)
  );

  seq_arb_judge #(.NUM_IDS(NUM_IDS)) u_judge (
    .own_idx (src_id),
    .tgt_idx (dst_id),
    .bus_id  (bus_id_in),
    .bus_sel (bus_sel_in),
    .own_bit (own_bit),
    .tgt_bit (tgt_bit),
    .win     (arb_win)
  );

  seq_delay_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  assign bus_free = !bus_bsy_in && !bus_sel_in;

  state_t             state_q, state_d, ret_q, ret_d;
  logic [NUM_IDS-1:0] id_q, id_d;
  logic               bsy_q, bsy_d, sel_q, sel_d, atn_q, atn_d;
  logic               done_q, done_d, lost_q, lost_d, tmo_q, tmo_d, srst_q, srst_d;

  always_comb begin
    state_d  = state_q;
    ret_d    = ret_q;
    id_d     = id_q;
    bsy_d    = bsy_q;
    sel_d    = sel_q;
    atn_d    = atn_q;
    done_d   = 1'b0;
    lost_d   = 1'b0;
    tmo_d    = 1'b0;
    srst_d   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          case (op)
            OP_ARB: begin
              id_d    = '0;
              bsy_d   = 1'b0;
              sel_d   = 1'b0;
              atn_d   = 1'b0;
              state_d = ST_FREE_CHK;
            end
            OP_SEL: begin
              id_d     = own_bit | tgt_bit;
              bsy_d    = 1'b0;
              sel_d    = 1'b1;
              atn_d    = atn_req;
              tmr_load = 1'b1;
              tmr_val  = CW'(SEL_TMO_CYC - 1);
              state_d  = ST_SEL_WAIT;
            end
            OP_BUSFREE, OP_ENRESEL, OP_DISRES: done_d = 1'b1;
            OP_RESET: begin
              done_d = 1'b1;
              srst_d = 1'b1;
            end
            default: ;
          endcase
        end
      end
      ST_FREE_CHK: begin
        tmr_load = 1'b1;
        state_d  = ST_WAIT;
        if (bus_free) begin
          tmr_val = CW'(FREE_SET_CYC - 1);
          ret_d   = ST_ARB_START;
        end else begin
          tmr_val = CW'(BUS_FREE_CYC - 1);
          ret_d   = ST_FREE_CHK;
        end
      end
      ST_WAIT: begin
        if (tmr_expired) state_d = ret_q;
      end
      ST_ARB_START: begin
        tmr_load = 1'b1;
        state_d  = ST_WAIT;
        if (bus_free) begin
          bsy_d   = 1'b1;
          id_d    = own_bit;
          tmr_val = CW'(ARB_CYC - 1);
          ret_d   = ST_ARB_END;
        end else begin
          id_d    = '0;
          bsy_d   = 1'b0;
          sel_d   = 1'b0;
          atn_d   = 1'b0;
          tmr_val = CW'(CLEAR_CYC - 1);
          ret_d   = ST_FREE_CHK;
        end
      end
      ST_ARB_END: begin
        done_d  = 1'b1;
        state_d = ST_IDLE;
        if (arb_win) begin
          sel_d = 1'b1;
        end else begin
          id_d   = '0;
          bsy_d  = 1'b0;
          sel_d  = 1'b0;
          atn_d  = 1'b0;
          lost_d = 1'b1;
        end
      end
      ST_SEL_WAIT: begin
        if (bus_bsy_in) begin
          sel_d   = 1'b0;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else if (tmr_expired) begin
          id_d    = '0;
          bsy_d   = 1'b0;
          sel_d   = 1'b0;
          atn_d   = 1'b0;
          tmo_d   = 1'b1;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      ret_q   <= ST_IDLE;
      id_q    <= '0;
      bsy_q   <= 1'b0;
      sel_q   <= 1'b0;
      atn_q   <= 1'b0;
      done_q  <= 1'b0;
      lost_q  <= 1'b0;
      tmo_q   <= 1'b0;
      srst_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ret_q   <= ret_d;
      id_q    <= id_d;
      bsy_q   <= bsy_d;
      sel_q   <= sel_d;
      atn_q   <= atn_d;
      done_q  <= done_d;
      lost_q  <= lost_d;
      tmo_q   <= tmo_d;
      srst_q  <= srst_d;
    end
  end

  assign id_out       = id_q;
  assign bsy_out      = bsy_q;
  assign sel_out      = sel_q;
  assign atn_out      = atn_q;
  assign busy         = (state_q != ST_IDLE);
  assign cmd_done     = done_q;
  assign exc_arb_lost = lost_q;
  assign exc_sel_tmo  = tmo_q;
  assign soft_rst     = srst_q;
endmodule

// File: rtl/scsi_arbsel_seq_chk.sv
module scsi_arbsel_seq_chk #(
  parameter int NUM_IDS = 8,
  localparam int IDX_W  = $clog2(NUM_IDS)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic [7:0]         cmd_code,
  input logic [IDX_W-1:0]   src_id,
  input logic [IDX_W-1:0]   dst_id,
  input logic [NUM_IDS-1:0] id_out,
  input logic               bsy_out,
  input logic               sel_out,
  input logic               atn_out,
  input logic               busy,
  input logic               cmd_done,
  input logic               exc_arb_lost,
  input logic               exc_sel_tmo,
  input logic               soft_rst
);
  a_r2_soft_rst_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> cmd_done && !exc_arb_lost && !exc_sel_tmo);

  a_r5_win_raises_sel: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_out) && bsy_out |-> cmd_done && !exc_arb_lost);

  a_r6_loss_releases: assert property (@(posedge clk) disable iff (!rst_n)
    exc_arb_lost |-> cmd_done && id_out == '0 && !bsy_out && !sel_out && !atn_out);

  a_r7_select_drive: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_out) && !bsy_out |-> id_out == ((NUM_IDS'(1) << src_id) | (NUM_IDS'(1) << dst_id)));

  a_r9_timeout_releases: assert property (@(posedge clk) disable iff (!rst_n)
    exc_sel_tmo |-> cmd_done && id_out == '0 && !bsy_out && !sel_out && !atn_out);

  a_r9_single_exception: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_arb_lost && exc_sel_tmo));

  a_r10_unsupported_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && cmd_valid && (cmd_code[3:0] == 4'd0 || cmd_code[3:0] > 4'd6)
    |=> !cmd_done && !busy);

  a_r11_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> !busy);

  a_r11_busy_ignores_reset: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_valid && cmd_code[3:0] == 4'd6 |=> !soft_rst);
endmodule

bind scsi_arbsel_seq scsi_arbsel_seq_chk #(.NUM_IDS(NUM_IDS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .cmd_code     (cmd_code),
  .src_id       (src_id),
  .dst_id       (dst_id),
  .id_out       (id_out),
  .bsy_out      (bsy_out),
  .sel_out      (sel_out),
  .atn_out      (atn_out),
  .busy         (busy),
  .cmd_done     (cmd_done),
  .exc_arb_lost (exc_arb_lost),
  .exc_sel_tmo  (exc_sel_tmo),
  .soft_rst     (soft_rst)
);

// File: tb/scsi_arbsel_seq_bench.sv
`timescale 1ns/1ps
module scsi_arbsel_seq_bench;
  localparam int BF = 8, ST = 4, CL = 8, AR = 24, TM = 200;
  localparam int ARB_MIN = BF + ST + AR;

  logic       clk;
  logic       rst_n;
  logic       cmd_valid;
  logic [7:0] cmd_code;
  logic [2:0] src_id, dst_id;
  logic [7:0] bus_id_in;
  logic       bus_bsy_in, bus_sel_in;
  logic [7:0] id_out;
  logic       bsy_out, sel_out, atn_out, busy, cmd_done, exc_arb_lost, exc_sel_tmo, soft_rst;

  scsi_arbsel_seq #(
    .NUM_IDS(8), .BUS_FREE_CYC(BF), .SETTLE_CYC(ST), .CLEAR_CYC(CL),
    .ARB_CYC(AR), .SEL_TMO_CYC(TM)
  ) u_scsi_arbsel_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .src_id(src_id), .dst_id(dst_id), .bus_id_in(bus_id_in),
    .bus_bsy_in(bus_bsy_in), .bus_sel_in(bus_sel_in), .id_out(id_out),
    .bsy_out(bsy_out), .sel_out(sel_out), .atn_out(atn_out), .busy(busy),
    .cmd_done(cmd_done), .exc_arb_lost(exc_arb_lost), .exc_sel_tmo(exc_sel_tmo),
    .soft_rst(soft_rst)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int done_cnt = 0;
  logic [2:0] exp_q[$];
  string      tag_q[$];
  logic [2:0] exp_item;
  string      exp_tag;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // monitor: flags are {exc_arb_lost, exc_sel_tmo, soft_rst}
  always @(negedge clk) begin
    if (rst_n && cmd_done) begin
      done_cnt++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R11", "unexpected done", 1, 0);
      end else begin
        exp_item = exp_q.pop_front();
        exp_tag  = tag_q.pop_front();
        check({exc_arb_lost, exc_sel_tmo, soft_rst} == exp_item, exp_tag,
              "completion flags", int'({exc_arb_lost, exc_sel_tmo, soft_rst}), int'(exp_item));
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #5;
    end
  endtask

  task automatic issue(input logic [7:0] code, input bit push,
                       input logic [2:0] flags, input string tag);
    tick(1);
    if (push) begin
      exp_q.push_back(flags);
      tag_q.push_back(tag);
    end
    cmd_valid = 1'b1;
    cmd_code  = code;
    tick(1);
    cmd_valid = 1'b0;
    cmd_code  = 8'h00;
  endtask

  task automatic wait_done(input int start, input string tag, output int cyc);
    cyc = 0;
    while (done_cnt == start && cyc < 3000) begin
      tick(1);
      cyc++;
    end
    check(done_cnt != start, tag, "done arrived", done_cnt - start, 1);
  endtask

  task automatic run(input logic [7:0] code, input logic [2:0] flags,
                     input string tag, output int cyc);
    int start;
    start = done_cnt;
    issue(code, 1'b1, flags, tag);
    wait_done(start, tag, cyc);
  endtask

  initial begin
    #(20.0 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int cyc;
    int start;
    cmd_valid = 1'b0; cmd_code = 8'h00; src_id = 3'd5; dst_id = 3'd2;
    bus_id_in = 8'h00; bus_bsy_in = 1'b0; bus_sel_in = 1'b0;
    rst_n = 1'b0;
    tick(4);
    // R12 reset state
    check({id_out, bsy_out, sel_out, atn_out, busy, cmd_done, exc_arb_lost, exc_sel_tmo, soft_rst} == '0,
          "R12", "outputs in reset", int'(id_out), 0);
    rst_n = 1'b1;
    tick(4);
    check(busy == 1'b0 && id_out == 8'h00, "R12", "idle after reset", int'(busy), 0);

    // R2 immediate commands
    run(8'h03, 3'b000, "R2", cyc); check(cyc == 1, "R2", "bus-free latency", cyc, 1);
    run(8'h04, 3'b000, "R2", cyc);
    run(8'h05, 3'b000, "R2", cyc);
    run(8'h06, 3'b001, "R2", cyc); check(cyc == 1, "R2", "reset latency", cyc, 1);

    // R1 upper bits ignored
    run(8'hD3, 3'b000, "R1", cyc);
    run(8'h16, 3'b001, "R1", cyc);

    // R10 unsupported codes
    start = done_cnt;
    issue(8'h00, 1'b0, 3'b000, "R10");
    issue(8'h0F, 1'b0, 3'b000, "R10");
    issue(8'h27, 1'b0, 3'b000, "R10");
    tick(20);
    check(done_cnt == start, "R10", "no done for unsupported", done_cnt - start, 0);
    check(busy == 1'b0, "R10", "stays idle", int'(busy), 0);

    // R5 win against lower ID
    bus_id_in = 8'h04;
    run(8'h01, 3'b000, "R5", cyc);
    check(cyc >= ARB_MIN && cyc <= ARB_MIN + 8, "R5", "arbitration latency", cyc, ARB_MIN + 4);
    check(sel_out && bsy_out && id_out == 8'h20, "R5", "won lines",
          int'({sel_out, bsy_out, id_out}), int'({2'b11, 8'h20}));
    bus_id_in = 8'h00;

    // R7 / R8 select with ATN, target answers
    start = done_cnt;
    issue(8'h22, 1'b1, 3'b000, "R8");
    tick(3);
    check(id_out == 8'h24, "R7", "select id bits", int'(id_out), 8'h24);
    check(sel_out && !bsy_out && atn_out, "R7", "select sel/bsy/atn",
          int'({sel_out, bsy_out, atn_out}), 3'b101);
    check(busy == 1'b1, "R11", "busy during select", int'(busy), 1);
    bus_bsy_in = 1'b1;
    wait_done(start, "R8", cyc);
    check(!sel_out && id_out == 8'h24 && atn_out, "R8", "after answer",
          int'({sel_out, atn_out, id_out}), int'({2'b01, 8'h24}));
    bus_bsy_in = 1'b0;

    // R9 selection timeout without ATN
    dst_id = 3'd3;
    start = done_cnt;
    issue(8'h02, 1'b1, 3'b010, "R9");
    tick(2);
    check(atn_out == 1'b0 && id_out == 8'h28, "R7", "no atn select", int'({atn_out, id_out}), 8'h28);
    wait_done(start, "R9", cyc);
    cyc = cyc + 2;
    check(cyc >= TM && cyc <= TM + 4, "R9", "timeout latency", cyc, TM + 1);
    check(id_out == 8'h00 && !sel_out && !bsy_out && !atn_out, "R9", "released after timeout",
          int'(id_out), 0);

    // R6 loss to higher ID
    bus_id_in = 8'h40;
    run(8'h01, 3'b100, "R6", cyc);
    check(id_out == 8'h00 && !bsy_out && !sel_out, "R6", "released after loss", int'(id_out), 0);
    bus_id_in = 8'h00;

    // R6 loss to foreign SEL during arbitration window
    start = done_cnt;
    issue(8'h01, 1'b1, 3'b100, "R6");
    tick(20);
    check(bsy_out && id_out == 8'h20, "R5", "arbitrating lines", int'(id_out), 8'h20);
    bus_sel_in = 1'b1;
    wait_done(start, "R6", cyc);
    bus_sel_in = 1'b0;

    // R5 boundaries: top ID always wins, ID 0 loses to anyone
    src_id = 3'd7; bus_id_in = 8'h7F;
    run(8'h01, 3'b000, "R5", cyc);
    check(id_out == 8'h80 && sel_out, "R5", "top id wins", int'(id_out), 8'h80);
    src_id = 3'd0; bus_id_in = 8'h02;
    run(8'h01, 3'b100, "R6", cyc);
    bus_id_in = 8'h00; src_id = 3'd5;

    // R3 bus busy before arbitrate
    bus_bsy_in = 1'b1;
    start = done_cnt;
    issue(8'h01, 1'b1, 3'b000, "R3");
    tick(60);
    check(done_cnt == start, "R3", "no done while bus busy", done_cnt - start, 0);
    check(id_out == 8'h00 && !bsy_out && !sel_out, "R3", "lines released while waiting",
          int'({bsy_out, sel_out, id_out}), 0);
    bus_bsy_in = 1'b0;
    wait_done(start, "R3", cyc);
    check(cyc >= ARB_MIN, "R3", "full delays after free", cyc, ARB_MIN);

    // R4 bus taken again before arbitration start
    start = done_cnt;
    issue(8'h01, 1'b1, 3'b000, "R4");
    tick(4);
    bus_bsy_in = 1'b1;
    tick(60);
    check(done_cnt == start, "R4", "no done while bus retaken", done_cnt - start, 0);
    check(id_out == 8'h00 && !bsy_out, "R4", "no drive on busy bus", int'({bsy_out, id_out}), 0);
    bus_bsy_in = 1'b0;
    wait_done(start, "R4", cyc);
    check(cyc >= ARB_MIN, "R4", "rearbitration delay", cyc, ARB_MIN);
    check(id_out == 8'h20 && sel_out, "R4", "win after retry", int'(id_out), 8'h20);

    // R11 commands during busy ignored
    start = done_cnt;
    issue(8'h01, 1'b1, 3'b000, "R11");
    check(busy == 1'b1, "R11", "busy after arbitrate", int'(busy), 1);
    issue(8'h06, 1'b0, 3'b000, "R11");
    issue(8'h03, 1'b0, 3'b000, "R11");
    wait_done(start, "R11", cyc);
    tick(10);
    check(done_cnt == start + 1, "R11", "single done", done_cnt - start, 1);
    check(busy == 1'b0, "R11", "idle after done", int'(busy), 0);
    check(exp_q.size() == 0, "R11", "scoreboard drained", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule